// File: doc/BRIEF.md
# Byte-Framed SPI Slave with Ready/Acknowledge Byte Interface

This block is an SPI slave that runs entirely on a fast system clock. It treats the serial clock, the active-low select and the serial data input as ordinary signals. Each one passes through a two-flop synchronizer, and the block then detects edges on the synchronized levels. Bytes are exchanged with the surrounding logic one whole byte at a time. A supplier offers an outgoing byte with a ready level and gets a one-cycle acknowledge when that byte has entered the transmit shifter. Received bytes appear on a data output together with a sticky valid flag and a one-cycle new-byte strobe. Nothing can hold back the master, so the consumer must keep up with the bus rate.

Transmission always stays on 8-bit boundaries. A byte offered while the slave is idle waits until the first bit after selection. A byte offered in the middle of a byte waits for the next boundary, and zeros are sent until then. Deselecting the slave at any point releases the serial output and returns the bit position to zero. A falling serial-clock edge seen after selection but before the first rising edge is discarded, so a clock that idles high when select goes low does not shift the frame.

Top module: `byte_spi_slave`

## Requirements
- R1: While select is high, miso_oe_o is low (serial output released) and the internal MISO bit is cleared one cycle later.
- R2: While selected with no byte loaded for transmission, miso_oe_o is high and miso_o is low.
- R3: Bits move most-significant first in both directions. The MISO bit changes only after a rising serial-clock edge, and MOSI is sampled on falling edges.
- R4: After select goes low, a falling serial-clock edge that comes before the first rising edge is ignored. A rising edge counts only if select was already low one system cycle earlier.
- R5: Deselecting mid-byte returns the bit position to zero, so the next selection starts a fresh byte.
- R6: A byte offered while a byte is already in progress starts at the next byte boundary. Until then miso_o sends zeros.
- R7: A byte offered before selection is held pending and appears from the first bit after selection.
- R8: tx_ack_o pulses for exactly one cycle when the held byte enters the shift register. A new byte is captured only after that pulse.
- R9: Each completed received byte updates rx_data_o, sets rx_valid_o (which stays set until reset) and pulses rx_new_o for exactly one system cycle.
- R10: The active-low reset clears the shifters, bit position, pending and valid flags and the acknowledge and strobe outputs, and leaves the serial output released.
- R11: Bytes queued back to back are sent on consecutive byte slots with no gap bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sck_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the external MISO tristate |
| tx_valid_i | input | 1 | Outgoing byte on tx_data_i is offered |
| tx_data_i | input | DATA_W | Outgoing byte |
| tx_ack_o | output | 1 | One-cycle pulse: offered byte has been consumed |
| rx_data_o | output | DATA_W | Last complete byte from the master |
| rx_valid_o | output | 1 | Set once any byte has been received |
| rx_new_o | output | 1 | One-cycle strobe per received byte |

## Verification
The assertions assume that the serial clock is slower than a quarter of the system clock, so each synchronized level holds for several cycles and rises and falls never fall in the same cycle. They also assume that MOSI is stable around each falling edge and that the supplier keeps tx_data_i steady until it sees tx_ack_o. The bench master holds every serial-clock phase for eight system cycles. It changes MOSI only together with a rising edge and changes select only while the serial clock is steady. The supplier advances its queue only in the half-cycle after an acknowledge.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int unsigned SPIS_BYTE_W = 8;

  typedef struct packed {
    logic rise;
    logic fall;
  } spis_edge_t;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spis_edge.sv
module spis_edge
  import spis_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  output spis_edge_t edge_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  always_comb begin
    edge_o.rise = lvl_i & ~prev_q;
    edge_o.fall = ~lvl_i & prev_q;
  end
endmodule

// File: rtl/spis_rx.sv
module spis_rx #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              strobe_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d, data_q, data_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              valid_q, valid_d, strobe_q, strobe_d;
  logic              take;

  assign take = sel_i & fall_i;

  always_comb begin
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    data_d   = data_q;
    valid_d  = valid_q;
    strobe_d = 1'b0;
    if (!sel_i) begin
      cnt_d = '0;
    end else if (take) begin
      sh_d = {sh_q[DATA_W-2:0], mosi_i};
      if (cnt_q == LAST) begin
        cnt_d    = '0;
        data_d   = {sh_q[DATA_W-2:0], mosi_i};
        valid_d  = 1'b1;
        strobe_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      data_q   <= '0;
      valid_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      data_q   <= data_d;
      valid_q  <= valid_d;
      strobe_q <= strobe_d;
    end
  end

  assign data_o   = data_q;
  assign valid_o  = valid_q;
  assign strobe_o = strobe_q;
  assign cnt_o    = cnt_q;

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
  assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);
  assert_strobe_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> valid_q);
  assert_deselect_realign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> (cnt_q == '0));
endmodule

// File: rtl/spis_tx.sv
module spis_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              rise_i,
  input  logic              boundary_i,
  input  logic              offer_i,
  input  logic [DATA_W-1:0] offer_data_i,
  output logic              ack_o,
  output logic              miso_o
);
  logic [DATA_W-1:0] hold_q, hold_d, sh_q, sh_d;
  logic              pend_q, pend_d, miso_q, miso_d, ack_q, ack_d;
  logic              load, capture;

  assign load    = sel_i & rise_i & boundary_i & pend_q;
  assign capture = offer_i & ~pend_q & ~ack_q;

  always_comb begin
    hold_d = hold_q;
    pend_d = pend_q;
    sh_d   = sh_q;
    miso_d = miso_q;
    ack_d  = 1'b0;
    if (!sel_i) begin
      sh_d   = '0;
      miso_d = 1'b0;
    end else if (rise_i) begin
      if (boundary_i) begin
        if (pend_q) begin
          miso_d = hold_q[DATA_W-1];
          sh_d   = {hold_q[DATA_W-2:0], 1'b0};
          pend_d = 1'b0;
          ack_d  = 1'b1;
        end else begin
          miso_d = 1'b0;
          sh_d   = '0;
        end
      end else begin
        miso_d = sh_q[DATA_W-1];
        sh_d   = {sh_q[DATA_W-2:0], 1'b0};
      end
    end
    if (capture) begin
      hold_d = offer_data_i;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      sh_q   <= '0;
      miso_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      pend_q <= pend_d;
      sh_q   <= sh_d;
      miso_q <= miso_d;
      ack_q  <= ack_d;
    end
  end

  assign ack_o  = ack_q;
  assign miso_o = miso_q;

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  assert_pending_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !load) |=> pend_q);
  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && rise_i && boundary_i && !pend_q) |=> !miso_q);
  assert_miso_moves_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !rise_i) |=> $stable(miso_q));
  assert_miso_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !miso_q);
endmodule

// File: rtl/byte_spi_slave.sv
module byte_spi_slave
  import spis_pkg::*;
#(
  parameter int unsigned DATA_W      = SPIS_BYTE_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ack_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_new_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // synchronize the three pad inputs: {sck, ss_n, mosi}
  logic [2:0] pads_s;
  spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({sck_i, ss_n_i, mosi_i}),
    .q     (pads_s)
  );

  logic sck_s, sel_s, mosi_s;
  assign sck_s  = pads_s[2];
  assign sel_s  = ~pads_s[1];
  assign mosi_s = pads_s[0];

  spis_edge_t sck_edge;
  spis_edge #(.RST_VAL(1'b0)) u_sck_edge (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .lvl_i  (sck_s),
    .edge_o (sck_edge)
  );

  // selection guard: rises need select held one cycle; falls need a prior rise
  logic sel_prev_q, started_q, started_d;
  logic rise_ok, fall_ok;

  assign rise_ok = sck_edge.rise & sel_s & sel_prev_q;
  assign fall_ok = sck_edge.fall & sel_s & started_q;

  always_comb begin
    started_d = started_q;
    if (!sel_s)       started_d = 1'b0;
    else if (rise_ok) started_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sel_prev_q <= 1'b0;
      started_q  <= 1'b0;
    end else begin
      sel_prev_q <= sel_s;
      started_q  <= started_d;
    end
  end

  logic [CNT_W-1:0] bit_cnt;
  logic             boundary;

  spis_rx #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sel_i    (sel_s),
    .fall_i   (fall_ok),
    .mosi_i   (mosi_s),
    .data_o   (rx_data_o),
    .valid_o  (rx_valid_o),
    .strobe_o (rx_new_o),
    .cnt_o    (bit_cnt)
  );

  assign boundary = (bit_cnt == '0);

  spis_tx #(.DATA_W(DATA_W)) u_tx (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .sel_i        (sel_s),
    .rise_i       (rise_ok),
    .boundary_i   (boundary),
    .offer_i      (tx_valid_i),
    .offer_data_i (tx_data_i),
    .ack_o        (tx_ack_o),
    .miso_o       (miso_o)
  );

  assign miso_oe_o = sel_s;

  assert_early_fall_ignored_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sck_edge.fall && !started_q) |=> $stable(bit_cnt));
  assert_oe_released_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!sel_s && !sel_prev_q) |-> (!miso_oe_o && !miso_o));
  assert_no_ack_unselected_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !sel_s |=> !tx_ack_o);
endmodule

// File: tb/sim_byte_spi_slave.sv
module sim_byte_spi_slave;
  localparam int H = 8;

  logic       clk, rst_n, sck, ss_n, mosi, dready;
  logic [7:0] dval;
  logic       miso_o, miso_oe_o, tx_ack_o, rx_valid_o, rx_new_o;
  logic [7:0] rx_data_o;

  byte_spi_slave u0 (
    .clk (clk), .rst_n (rst_n), .sck_i (sck), .ss_n_i (ss_n), .mosi_i (mosi),
    .miso_o (miso_o), .miso_oe_o (miso_oe_o), .tx_valid_i (dready),
    .tx_data_i (dval), .tx_ack_o (tx_ack_o), .rx_data_o (rx_data_o),
    .rx_valid_o (rx_valid_o), .rx_new_o (rx_new_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int acks = 0, strobes = 0, run = 0, maxrun = 0;
  logic [7:0] q [0:15];
  int q_wr = 0, q_rd = 0;
  bit done = 0;

  // supplier: present queue head, advance on acknowledge
  always @(negedge clk) begin
    if (tx_ack_o) begin
      acks++;
      q_rd++;
    end
    dready = (q_rd < q_wr);
    dval   = (q_rd < q_wr) ? q[q_rd] : 8'h00;
    if (rx_new_o) begin
      strobes++;
      run++;
      if (run > maxrun) maxrun = run;
    end else run = 0;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic enqueue(input logic [7:0] b);
    q[q_wr] = b;
    q_wr++;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select;   ss_n = 1'b0; wait_n(H); endtask
  task automatic deselect; ss_n = 1'b1; wait_n(H); endtask

  task automatic spi_bit(input logic b, output logic m);
    mosi = b; sck = 1'b1; wait_n(H);
    m = miso_o; sck = 1'b0; wait_n(H);
  endtask

  task automatic xchg(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) spi_bit(mo[i], mi[i]);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sck = 1'b0; ss_n = 1'b1; mosi = 1'b0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    check(!miso_oe_o, "R10 oe after reset", miso_oe_o, 0);
    check(rx_valid_o == 1'b0 && rx_data_o == 8'h00, "R10 rx after reset", rx_data_o, 0);
    check(acks == 0 && strobes == 0, "R10 no pulses after reset", acks + strobes, 0);
  endtask

  task automatic t_idle_select;
    check(!miso_oe_o, "R1 released while deselected", miso_oe_o, 0);
    select;
    check(miso_oe_o && !miso_o, "R2 driven low when empty", {miso_oe_o, miso_o}, 2);
    deselect;
    check(!miso_oe_o, "R1 released after deselect", miso_oe_o, 0);
  endtask

  task automatic t_preload;
    logic [7:0] mi;
    int a0 = acks, s0 = strobes;
    enqueue(8'hA5);
    wait_n(20);
    check(acks == a0, "R8 no ack before load", acks - a0, 0);
    select;
    xchg(8'h3C, mi);
    wait_n(H);
    check(mi == 8'hA5, "R7 preloaded byte msb first R3", mi, 8'hA5);
    check(rx_data_o == 8'h3C, "R3 received msb first", rx_data_o, 8'h3C);
    check(rx_valid_o, "R9 valid set", rx_valid_o, 1);
    check(strobes == s0 + 1, "R9 one strobe per byte", strobes - s0, 1);
    check(acks == a0 + 1, "R8 one ack per byte", acks - a0, 1);
    deselect;
  endtask

  task automatic t_late;
    logic [7:0] mi, mi2;
    logic m;
    select;
    for (int i = 7; i >= 5; i--) begin spi_bit(1'b0, m); mi[i] = m; end
    enqueue(8'h5A);
    for (int i = 4; i >= 0; i--) begin spi_bit(1'b0, m); mi[i] = m; end
    check(mi == 8'h00, "R6 zeros until boundary", mi, 0);
    xchg(8'h00, mi2);
    check(mi2 == 8'h5A, "R6 late byte at next boundary", mi2, 8'h5A);
    deselect;
  endtask

  task automatic t_desel;
    logic [7:0] mi;
    logic m;
    int s0 = strobes;
    select;
    for (int i = 0; i < 3; i++) spi_bit(1'b1, m);
    ss_n = 1'b1;
    wait_n(4);
    check(!miso_oe_o, "R1 release on mid-byte deselect", miso_oe_o, 0);
    wait_n(H);
    check(strobes == s0, "R5 no strobe for partial byte", strobes - s0, 0);
    select;
    xchg(8'h81, mi);
    wait_n(H);
    check(rx_data_o == 8'h81, "R5 realigned after deselect", rx_data_o, 8'h81);
    check(strobes == s0 + 1, "R5 one byte after reselect", strobes - s0, 1);
    deselect;
  endtask

  task automatic t_guard;
    logic [7:0] mi;
    int s0 = strobes;
    sck = 1'b1; wait_n(H);
    select;
    sck = 1'b0; wait_n(H);
    xchg(8'hC3, mi);
    wait_n(H);
    check(rx_data_o == 8'hC3, "R4 early fall ignored", rx_data_o, 8'hC3);
    check(strobes == s0 + 1, "R4 byte count", strobes - s0, 1);
    deselect;
  endtask

  task automatic t_burst;
    logic [7:0] m1, m2, m3, m4;
    int a0 = acks;
    enqueue(8'h11); enqueue(8'h22); enqueue(8'h33);
    wait_n(4);
    select;
    xchg(8'hE1, m1);
    xchg(8'h1E, m2);
    xchg(8'h7F, m3);
    wait_n(H);
    check(m1 == 8'h11, "R11 first burst byte", m1, 8'h11);
    check(m2 == 8'h22, "R11 second burst byte", m2, 8'h22);
    check(m3 == 8'h33, "R11 third burst byte", m3, 8'h33);
    check(rx_data_o == 8'h7F, "R9 last received byte", rx_data_o, 8'h7F);
    check(acks == a0 + 3, "R8 three acks", acks - a0, 3);
    xchg(8'h00, m4);
    check(m4 == 8'h00, "R2 zeros once queue empty", m4, 0);
    deselect;
  endtask

  initial begin
    t_reset;
    t_idle_select;
    t_preload;
    t_late;
    t_desel;
    t_guard;
    t_burst;
    check(maxrun == 1, "R9 strobe width one cycle", maxrun, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule